// File: doc/BRIEF.md
# Scannable Registered Bus Transceiver

This block sits between a local data path and a shared, bidirectional bus. A transmit register captures local data and, while the bus is enabled, drives it onto the shared bus pins. A receive register captures whatever value the bus pins resolve to, whether that is this block's own transmit value or a value driven by another agent. Each register has its own load/hold control. When load is low, the register keeps its current value.

Whether the bus is driven depends on a bus-enable flip-flop with three controls. A synchronous enable loads it on the clock edge. An asynchronous disable clears it at once. A re-enable mode input, when low, forces the flop's output set whenever the disable is not active. So re-enabling after a disable is either immediate (asynchronous) or waits for a clock edge with the synchronous enable high.

For test access, a scan mode links both registers into one serial shift chain. The chain runs from the serial input through transmit bits 0 to 2, then receive bits 0 to 2. Its last stage is the most significant receive output, which serves as the scan output.

Top module: `scan_bus_xcvr`

## Requirements
- R1: A rising clock edge with `rst_n` low clears both data registers and the bus-enable flop, so `rx_q` reads 0 and, with `sync_reen` high, `bus_oe` reads 0.
- R2: Outside scan mode, a rising edge with `ten` high loads `tx_d` into the transmit register without inversion; with `ten` low the transmit register holds.
- R3: Outside scan mode, a rising edge with `ren` high loads the resolved value of `bus_io` into `rx_q`; with `ren` low `rx_q` holds.
- R4: With `sync_reen` high and `abus_dis` low, `bus_oe` after each rising edge equals the value `sbus_en` had at that edge.
- R5: While `abus_dis` is high, `bus_oe` is 0 and `bus_io` is released, without waiting for a clock edge.
- R6: With `sync_reen` high, after `abus_dis` falls, `bus_oe` stays 0 until a rising edge samples `sbus_en` high.
- R7: With `sync_reen` low and `abus_dis` low, `bus_oe` is 1 immediately, whatever `sbus_en` is.
- R8: While `scan` is high, every rising edge shifts the chain `scan_in` -> transmit bit 0..2 -> receive bit 0..2, ignoring `ten`, `ren` and `tx_d`; `rx_q[2]` is the scan output.
- R9: While `bus_oe` is 1, `bus_io` carries the transmit register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_d | input | W | Local data to transmit |
| ten | input | 1 | Transmit load (1) / hold (0) |
| ren | input | 1 | Receive load (1) / hold (0) |
| sbus_en | input | 1 | Synchronous bus enable, sampled on the clock edge |
| abus_dis | input | 1 | Asynchronous bus disable, active high |
| sync_reen | input | 1 | 1: re-enable waits for the clock; 0: forced set, asynchronous re-enable |
| scan | input | 1 | Scan mode select, active high |
| scan_in | input | 1 | Serial scan data input |
| bus_io | inout | W | Shared bus pins, released when not enabled |
| rx_q | output | W | Receive register; bit W-1 is the scan output |
| bus_oe | output | 1 | Current state of the bus drive enable |

## Verification
The hardest case to reach is the asynchronous path of the enable. The disable and the forced set change `bus_oe` between clock edges, and the two re-enable modes differ only in what happens after the disable is released. The stimulus changes `abus_dis` in the middle of a clock period and samples a nanosecond later, before any edge. It then holds `sbus_en` low across an edge, so that the synchronous mode is seen to stay off while the forced-set mode is seen to stay on. Receive loading from another agent is reached by first turning the bus off and then driving the pins from the bench.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the scannable bus transceiver.
// Assumes: all register operations are decided once per clock edge.
package xcvr_pkg;

    // Operation applied to a side register on the next rising edge
    typedef enum logic [1:0] {
        REG_HOLD  = 2'd0,
        REG_LOAD  = 2'd1,
        REG_SHIFT = 2'd2
    } reg_op_e;

    // Pick the operation for one side from scan mode and its load enable
    function automatic reg_op_e pick_op(input logic scan_mode, input logic load_en);
        if (scan_mode)    return REG_SHIFT;
        else if (load_en) return REG_LOAD;
        else              return REG_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_side_reg.sv
// One side register of the transceiver (transmit or receive).
// Does: parallel load, hold through loopback, or one-bit serial shift
// toward the MSB. Assumes: synchronous active-low reset; op is stable
// around the rising edge.
module xcvr_side_reg
    import xcvr_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_op_e      op,
    input  logic [W-1:0] par_d,
    input  logic         ser_in,
    output logic [W-1:0] q
);

    logic [W-1:0] next_q;

    // Select the next register value for the requested operation
    always_comb begin
        unique case (op)
            REG_LOAD:  next_q = par_d;
            REG_SHIFT: next_q = {q[W-2:0], ser_in};
            default:   next_q = q;
        endcase
    end

    // Register the value, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= next_q;
    end

endmodule

// File: rtl/xcvr_bus_enable.sv
// Bus drive enable flop.
// Does: samples the synchronous enable on the rising edge. An active-high
// asynchronous disable clears it at once. An active-low forced-set input
// overrides the stored value whenever the disable is inactive.
// Assumes: abus_dis dominates every other control; reset is synchronous.
module xcvr_bus_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic sbus_en,
    input  logic abus_dis,
    input  logic sync_reen,
    output logic bus_oe
);

    logic en_q;

    // Enable state: async clear by the disable, else sync reset, else sample
    always_ff @(posedge clk or posedge abus_dis) begin
        if (abus_dis)      en_q <= 1'b0;
        else if (!rst_n)   en_q <= 1'b0;
        else               en_q <= sbus_en;
    end

    // Output: forced set when sync_reen is low, always blocked by the disable
    always_comb begin
        bus_oe = !abus_dis && (en_q || !sync_reen);
    end

endmodule

// File: rtl/scan_bus_xcvr.sv
// Scannable registered bus transceiver, top level.
// Does: transmit register drives the shared bus when enabled, receive
// register captures the resolved bus; in scan mode both registers form
// one chain ending at rx_q[W-1]. Assumes: W >= 2; another agent may
// drive bus_io only while bus_oe is 0.
module scan_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tx_d,
    input  logic         ten,
    input  logic         ren,
    input  logic         sbus_en,
    input  logic         abus_dis,
    input  logic         sync_reen,
    input  logic         scan,
    input  logic         scan_in,
    inout  wire  [W-1:0] bus_io,
    output logic [W-1:0] rx_q,
    output logic         bus_oe
);

    localparam int MSB = W - 1;

    logic [W-1:0] tx_q;
    reg_op_e      tx_op;
    reg_op_e      rx_op;

    // Decide each side's operation for the coming edge
    always_comb begin
        tx_op = pick_op(scan, ten);
        rx_op = pick_op(scan, ren);
    end

    xcvr_side_reg #(.W(W)) tx_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (tx_op),
        .par_d  (tx_d),
        .ser_in (scan_in),
        .q      (tx_q)
    );

    xcvr_side_reg #(.W(W)) rx_reg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (rx_op),
        .par_d  (bus_io),
        .ser_in (tx_q[MSB]),
        .q      (rx_q)
    );

    xcvr_bus_enable en_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sbus_en   (sbus_en),
        .abus_dis  (abus_dis),
        .sync_reen (sync_reen),
        .bus_oe    (bus_oe)
    );

    // Drive the bus from the transmit register only while enabled
    assign bus_io = bus_oe ? tx_q : {W{1'bz}};

endmodule

// File: rtl/xcvr_chk.sv
// Property checker for the scannable bus transceiver, bound to the top.
// Assumes: sampled on the rising clock; disabled while reset is low.
module xcvr_chk #(
    parameter int W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ren,
    input logic         sbus_en,
    input logic         abus_dis,
    input logic         sync_reen,
    input logic         scan,
    input logic [W-1:0] bus_io,
    input logic [W-1:0] rx_q,
    input logic         bus_oe
);

    // R3
    rx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan && ren) |=> (rx_q == $past(bus_io)));

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan && !ren) |=> $stable(rx_q));

    // R4
    sync_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_reen && !abus_dis && $past(sync_reen) && !$past(abus_dis) && $past(rst_n))
            |-> (bus_oe == $past(sbus_en)));

    // R5
    async_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abus_dis |-> !bus_oe);

    // R7
    forced_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_reen && !abus_dis) |-> bus_oe);

    // R8
    scan_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan |=> (rx_q[W-1:1] == $past(rx_q[W-2:0])));

endmodule

bind scan_bus_xcvr xcvr_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ren       (ren),
    .sbus_en   (sbus_en),
    .abus_dis  (abus_dis),
    .sync_reen (sync_reen),
    .scan      (scan),
    .bus_io    (bus_io),
    .rx_q      (rx_q),
    .bus_oe    (bus_oe)
);

// File: tb/scan_bus_xcvr_tb_top.sv
// Self-checking bench for scan_bus_xcvr: table-driven load/hold walk,
// then directed tests for reset, external bus drive, enable modes, scan.
module scan_bus_xcvr_tb_top;

    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tx_d = '0;
    logic         ten = 1'b0;
    logic         ren = 1'b0;
    logic         sbus_en = 1'b0;
    logic         abus_dis = 1'b0;
    logic         sync_reen = 1'b1;
    logic         scan = 1'b0;
    logic         scan_in = 1'b0;
    logic         drv_en = 1'b0;
    logic [W-1:0] drv_val = '0;
    tri   [W-1:0] bus_w;
    logic [W-1:0] rx_q;
    logic         bus_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign bus_w = drv_en ? drv_val : {W{1'bz}};

    always #10 clk = ~clk;

    scan_bus_xcvr #(.W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_d      (tx_d),
        .ten       (ten),
        .ren       (ren),
        .sbus_en   (sbus_en),
        .abus_dis  (abus_dis),
        .sync_reen (sync_reen),
        .scan      (scan),
        .scan_in   (scan_in),
        .bus_io    (bus_w),
        .rx_q      (rx_q),
        .bus_oe    (bus_oe)
    );

    // Row: ten, tx_d, ren, sbus_en, exp_oe, exp_rx, exp_bus
    typedef struct packed {
        logic         ten;
        logic [W-1:0] d;
        logic         ren;
        logic         sen;
        logic         oe;
        logic [W-1:0] rx;
        logic [W-1:0] bus;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 3'd0, 3'd5},
        '{1'b0, 3'd2, 1'b1, 1'b1, 1'b1, 3'd5, 3'd5},
        '{1'b1, 3'd3, 1'b0, 1'b1, 1'b1, 3'd5, 3'd3},
        '{1'b0, 3'd6, 1'b1, 1'b1, 1'b1, 3'd3, 3'd3},
        '{1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 3'd3, 3'd0},
        '{1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 3'd3, 3'd6},
        '{1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 3'd6, 3'd6},
        '{1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 3'd6, 3'd1},
        '{1'b0, 3'd4, 1'b1, 1'b1, 1'b1, 3'd1, 3'd1}
    };

    // Count one comparison and report a mismatch
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Advance one rising edge, then move 5 ns away from it
    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0; sbus_en = 1'b1;
        tick(); tick();
        check("R1 rx", rx_q, '0);
        check("R1 oe", {2'b0, bus_oe}, 3'd0);
        rst_n = 1'b1;

        // R2/R3/R4/R9: table walk with sync_reen high
        for (int i = 0; i < NV; i++) begin
            ten = VECS[i].ten; tx_d = VECS[i].d;
            ren = VECS[i].ren; sbus_en = VECS[i].sen;
            tick();
            check("R4 oe", {2'b0, bus_oe}, {2'b0, VECS[i].oe});
            check("R3 rx", rx_q, VECS[i].rx);
            if (VECS[i].oe) check("R2/R9 bus", bus_w, VECS[i].bus);
        end

        // R3: load from another agent while the bus is off, then hold
        ten = 1'b0; sbus_en = 1'b0; ren = 1'b0;
        tick();
        check("R4 off", {2'b0, bus_oe}, 3'd0);
        drv_val = 3'd7; drv_en = 1'b1; ren = 1'b1;
        tick();
        check("R3 ext load", rx_q, 3'd7);
        drv_val = 3'd2; ren = 1'b0;
        tick();
        check("R3 hold", rx_q, 3'd7);
        drv_en = 1'b0;

        // R5: async disable mid-cycle
        sbus_en = 1'b1;
        tick();
        check("R4 on", {2'b0, bus_oe}, 3'd1);
        abus_dis = 1'b1;
        #1;
        check("R5 async off", {2'b0, bus_oe}, 3'd0);
        tick();
        check("R5 held off", {2'b0, bus_oe}, 3'd0);

        // R6: synchronous re-enable
        sbus_en = 1'b0;
        abus_dis = 1'b0;
        #1;
        check("R6 stays off", {2'b0, bus_oe}, 3'd0);
        tick();
        check("R6 off after edge", {2'b0, bus_oe}, 3'd0);
        sbus_en = 1'b1;
        tick();
        check("R6 on after edge", {2'b0, bus_oe}, 3'd1);

        // R7: forced set gives asynchronous re-enable
        sync_reen = 1'b0; sbus_en = 1'b0;
        abus_dis = 1'b1;
        #1;
        check("R7 disable wins", {2'b0, bus_oe}, 3'd0);
        abus_dis = 1'b0;
        #1;
        check("R7 async on", {2'b0, bus_oe}, 3'd1);
        tick();
        check("R7 on sbus low", {2'b0, bus_oe}, 3'd1);

        // R8: scan shift-through, ten/ren/tx_d ignored
        ten = 1'b1; ren = 1'b1; tx_d = 3'd7; scan = 1'b1;
        for (int k = 0; k < 6; k++) begin
            scan_in = (k == 1 || k == 4 || k == 5) ? 1'b0 : 1'b1;
            tick();
        end
        check("R8 rx after 6", rx_q, 3'b101);
        scan_in = 1'b0;
        for (int k = 0; k < 3; k++) tick();
        check("R8 rx after 9", rx_q, 3'b100);
        scan = 1'b0; ten = 1'b0; ren = 1'b0;
        #1;
        check("R8/R9 tx cleared by shift", bus_w, 3'b000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule